// File: doc/BRIEF.md
# DS3 C-Bit Parity Overhead Generator and Monitor

This block is the overhead stage of a DS3 framer running in C-bit parity mode. On the transmit side it runs a fixed position counter over the 4760-bit M-frame. In each slot it either takes one payload bit from the upstream source, which is told to supply one through `pay_rdy`, or it emits an overhead bit: X, P, M, F or one of the C bits. C-bit parity mode fills the C bits with an application identifier, the FEAC bit, data-link bits, a copy of the parity and the far-end block error (FEBE) indication. None of them control stuffing.

The receive side is a monitor. It is aligned by a marker on the first bit of an M-frame and tracks the incoming stream from then on. It checks the F and M pattern, checks both P bits and the three CP bits against the parity it computes over the previous frame, and counts FEBE indications that arrive. When a CP mismatch is found, it asks the transmit side to send zeros in the FEBE bits of the frame that is going out at that time.

Line coding and the lower multiplex stages are not part of this block. A transmit frame starts at the first cycle after reset, and the stream runs one bit per clock.

Top module: `ds3_cbit_ohg`

## Requirements
- R1: An M-frame is 4760 slots, made of 7 subframes of 8 blocks of 85 slots. Slot 0 of every block is overhead and slots 1..84 are payload. `pay_rdy` is high exactly in the payload slots. `tx_mstart` is high together with the `tx_bit` of the first slot of each frame.
- R2: `tx_bit` is registered: it carries a slot's value in the cycle after that slot. A payload slot outputs the `pay_bit` that was present while `pay_rdy` was high. After reset, `tx_bit`, `pay_rdy` and all counters are 0.
- R3: The overhead bits of blocks 2, 4, 6 and 8 (1-based) of every subframe are 1, 0, 0, 1.
- R4: The block-1 overhead bit of subframes 5, 6 and 7 is 0, 1 and 0.
- R5: The block-1 overhead bits of subframes 1 and 2 (the X bits) are equal. Both are the inverse of `rem_oof` as sampled in the first slot of the frame.
- R6: The block-1 overhead bits of subframes 3 and 4 (the P bits) are 1 if the 4704 payload bits of the previous transmitted frame hold an odd number of ones, and 0 otherwise. They are 0 in the first frame after reset.
- R7: The C bits sit in blocks 3, 5 and 7. In subframe 1 they are 1, 1 and then `feac_bit`. In subframe 3 they equal the P value. In subframes 2, 5, 6 and 7 they carry `dl_bit`, sampled in their slot.
- R8: The subframe-4 C bits (FEBE) are 0 in a frame if the monitor flagged a CP error before that frame's subframe 4 began, and 1 otherwise.
- R9: The monitor ignores its input until `rx_sync` is high. The bit present with `rx_sync` is taken as slot 0. The first frame after alignment makes no P or CP check.
- R10: `p_err_cnt` goes up by one, at most once per frame, when the two received P bits differ from each other or from the parity of the previous received frame's payload.
- R11: `cp_err_cnt` goes up by one per frame when any received CP bit differs from the previous frame's payload parity. The FEBE request then holds until the next frame's CP check.
- R12: `febe_cnt` goes up by one per frame when at least two of the three received FEBE bits are 0.
- R13: `frm_err_cnt` goes up by one for every received F or M bit that does not match R3 or R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pay_bit | input | 1 | Payload bit for the current slot |
| pay_rdy | output | 1 | High when the current slot consumes `pay_bit` |
| rem_oof | input | 1 | Remote out-of-frame report, drives the X bits |
| feac_bit | input | 1 | Value for the FEAC C bit |
| dl_bit | input | 1 | Value for the data-link C bits |
| tx_bit | output | 1 | Framed serial output |
| tx_mstart | output | 1 | Marks the first bit of a transmitted frame |
| rx_bit | input | 1 | Received serial stream |
| rx_sync | input | 1 | Marks the first bit of a received frame |
| p_err_cnt | output | CNT_W | P-bit error count |
| cp_err_cnt | output | CNT_W | CP-bit error count |
| febe_cnt | output | CNT_W | Received FEBE indication count |
| frm_err_cnt | output | CNT_W | F/M bit error count |

## Verification
A slip in the transmit position counter or state register shows up within one block, 85 bits: an F bit lands in a payload slot and `pay_rdy` toggles in the wrong cycle. A wrong parity accumulator stays hidden until the P and CP bits of the next frame, up to 4760 bits later. On loopback it then appears as a P error and a CP error, followed by a FEBE zero in that same frame. A monitor that counts before alignment, or that reports an error twice, is exposed by the error counters at frame boundaries after single-bit and double-bit payload errors and a single corrupted F bit.

// File: rtl/ds3_cbit_pkg.sv
package ds3_cbit_pkg;
    localparam int SUBFRAMES  = 7;
    localparam int BLOCKS     = 8;
    localparam int BLOCK_BITS = 85;
    localparam int SF_W       = $clog2(SUBFRAMES);
    localparam int BLK_W      = $clog2(BLOCKS);
    localparam int BIT_W      = $clog2(BLOCK_BITS);

    typedef struct packed {
        logic [SF_W-1:0]  sf;
        logic [BLK_W-1:0] blk;
        logic [BIT_W-1:0] bt;
    } ds3_pos_t;

    typedef enum logic {TX_OVH, TX_PAY} tx_state_e;
    typedef enum logic {RX_WAIT, RX_LOCK} rx_state_e;
endpackage

// File: rtl/ds3_pos_ctr.sv
module ds3_pos_ctr
    import ds3_cbit_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     restart,
    output ds3_pos_t pos,
    output logic     last
);
    ds3_pos_t cur_q;
    ds3_pos_t nxt;

    assign pos  = restart ? '0 : cur_q;
    assign last = (pos.sf == SF_W'(SUBFRAMES-1)) && (pos.blk == BLK_W'(BLOCKS-1))
                  && (pos.bt == BIT_W'(BLOCK_BITS-1));

    always_comb begin
        nxt = pos;
        if (pos.bt == BIT_W'(BLOCK_BITS-1)) begin
            nxt.bt = '0;
            if (pos.blk == BLK_W'(BLOCKS-1)) begin
                nxt.blk = '0;
                nxt.sf  = (pos.sf == SF_W'(SUBFRAMES-1)) ? '0 : pos.sf + 1'b1;
            end else begin
                nxt.blk = pos.blk + 1'b1;
            end
        end else begin
            nxt.bt = pos.bt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               cur_q <= '0;
        else if (en || restart)   cur_q <= nxt;
    end

    // R1: a frame always wraps back to slot 0
    assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (last && en && !restart) |=> (cur_q == '0));
endmodule

// File: rtl/ds3_cbit_tx.sv
module ds3_cbit_tx
    import ds3_cbit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pay_bit,
    output logic pay_rdy,
    input  logic rem_oof,
    input  logic feac_bit,
    input  logic dl_bit,
    input  logic febe_req,
    output logic tx_bit,
    output logic tx_mstart
);
    ds3_pos_t  pos;
    logic      last;
    tx_state_e state_q, state_d;
    logic      par_acc, par_prev, oof_lat, febe_lat;
    logic      frame_start, x_val, oh_val;
    logic      p_seen, p_slot_q, cp_slot_q, x1_seen, x2_slot_q;

    ds3_pos_ctr u_pos (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .restart(1'b0), .pos(pos), .last(last)
    );

    // next-state: the last payload slot of a block leads into overhead
    always_comb begin
        unique case (state_q)
            TX_OVH:  state_d = TX_PAY;
            TX_PAY:  state_d = (pos.bt == BIT_W'(BLOCK_BITS-1)) ? TX_OVH : TX_PAY;
            default: state_d = TX_OVH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_OVH;
        else        state_q <= state_d;
    end

    assign frame_start = (pos == '0);
    assign x_val       = frame_start ? ~rem_oof : ~oof_lat;

    always_comb begin
        oh_val = 1'b1;
        unique case (int'(pos.blk))
            0: begin
                unique case (int'(pos.sf))
                    0, 1:    oh_val = x_val;
                    2, 3:    oh_val = par_prev;
                    5:       oh_val = 1'b1;
                    default: oh_val = 1'b0;
                endcase
            end
            1, 7: oh_val = 1'b1;
            3, 5: oh_val = 1'b0;
            default: begin
                unique case (int'(pos.sf))
                    0:       oh_val = (int'(pos.blk) == 6) ? feac_bit : 1'b1;
                    2:       oh_val = par_prev;
                    3:       oh_val = ~febe_lat;
                    default: oh_val = dl_bit;
                endcase
            end
        endcase
    end

    // output process
    always_comb begin
        unique case (state_q)
            TX_PAY:  pay_rdy = 1'b1;
            default: pay_rdy = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit    <= 1'b0;
            tx_mstart <= 1'b0;
            par_acc   <= 1'b0;
            par_prev  <= 1'b0;
            oof_lat   <= 1'b0;
            febe_lat  <= 1'b0;
        end else begin
            tx_bit    <= pay_rdy ? pay_bit : oh_val;
            tx_mstart <= frame_start;
            if (frame_start) oof_lat <= rem_oof;
            if (pos.sf == SF_W'(3) && pos.blk == '0 && pos.bt == '0) febe_lat <= febe_req;
            if (pay_rdy) begin
                if (last) begin
                    par_prev <= par_acc ^ pay_bit;
                    par_acc  <= 1'b0;
                end else begin
                    par_acc  <= par_acc ^ pay_bit;
                end
            end
        end
    end

    // observation registers for the assertions below
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_seen <= 1'b0; p_slot_q <= 1'b0; cp_slot_q <= 1'b0;
            x1_seen <= 1'b0; x2_slot_q <= 1'b0;
        end else begin
            p_slot_q  <= (pos.sf == SF_W'(2)) && (pos.blk == '0) && (pos.bt == '0);
            cp_slot_q <= (pos.sf == SF_W'(2)) && (pos.blk == BLK_W'(2)) && (pos.bt == '0);
            x2_slot_q <= (pos.sf == SF_W'(1)) && (pos.blk == '0) && (pos.bt == '0);
            if (p_slot_q)  p_seen  <= tx_bit;
            if (tx_mstart) x1_seen <= tx_bit;
        end
    end

    assert_rdy_payload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pay_rdy |-> (pos.bt != '0));
    assert_fbit_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pos.bt == '0 && pos.blk == BLK_W'(1)) |-> tx_bit);
    assert_cp_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cp_slot_q |-> (tx_bit == p_seen));
    assert_x_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        x2_slot_q |-> (tx_bit == x1_seen));
endmodule

// File: rtl/ds3_cbit_rx.sv
module ds3_cbit_rx
    import ds3_cbit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_sync,
    output logic             febe_req,
    output logic [CNT_W-1:0] p_err_cnt,
    output logic [CNT_W-1:0] cp_err_cnt,
    output logic [CNT_W-1:0] febe_cnt,
    output logic [CNT_W-1:0] frm_err_cnt
);
    ds3_pos_t  pos;
    logic      last, active, is_oh, blk_c, blk_c6;
    rx_state_e state_q, state_d;
    logic      acc, prev_par, prev_ok, p1, cp_bad;
    logic [1:0] fe_zeros;
    logic      p_ev, cp_ev, fe_ev, frm_ev, cp_slot6;

    always_comb begin
        unique case (state_q)
            RX_WAIT: state_d = rx_sync ? RX_LOCK : RX_WAIT;
            RX_LOCK: state_d = RX_LOCK;
            default: state_d = RX_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_WAIT;
        else        state_q <= state_d;
    end

    assign active = (state_q == RX_LOCK) || rx_sync;

    ds3_pos_ctr u_pos (
        .clk(clk), .rst_n(rst_n), .en(active), .restart(rx_sync), .pos(pos), .last(last)
    );

    assign is_oh   = active && (pos.bt == '0);
    assign blk_c   = (int'(pos.blk) == 2) || (int'(pos.blk) == 4) || (int'(pos.blk) == 6);
    assign blk_c6  = (int'(pos.blk) == 6);
    assign cp_slot6 = is_oh && (pos.sf == SF_W'(2)) && blk_c6;

    always_comb begin
        frm_ev = 1'b0;
        if (is_oh && pos.blk[0])
            frm_ev = rx_bit != ((int'(pos.blk) == 1) || (int'(pos.blk) == 7));
        else if (is_oh && pos.blk == '0 && int'(pos.sf) >= 4)
            frm_ev = rx_bit != (pos.sf == SF_W'(5));
        p_ev  = is_oh && pos.blk == '0 && pos.sf == SF_W'(3) && prev_ok
                && ((rx_bit != p1) || (p1 != prev_par));
        cp_ev = cp_slot6 && prev_ok && (cp_bad || (rx_bit != prev_par));
        fe_ev = is_oh && (pos.sf == SF_W'(3)) && blk_c6
                && ((fe_zeros + {1'b0, ~rx_bit}) >= 2'd2);
    end

    function automatic logic [CNT_W-1:0] inc_sat(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= 1'b0; prev_par <= 1'b0; prev_ok <= 1'b0; p1 <= 1'b0;
            cp_bad <= 1'b0; fe_zeros <= 2'd0; febe_req <= 1'b0;
            p_err_cnt <= '0; cp_err_cnt <= '0; febe_cnt <= '0; frm_err_cnt <= '0;
        end else if (active) begin
            if (rx_sync)      acc <= 1'b0;
            else if (last) begin
                prev_par <= acc ^ rx_bit;
                acc      <= 1'b0;
                prev_ok  <= 1'b1;
            end else if (!is_oh) acc <= acc ^ rx_bit;
            if (is_oh && pos.blk == '0 && pos.sf == SF_W'(2)) p1 <= rx_bit;
            if (is_oh && pos.sf == SF_W'(2) && blk_c)
                cp_bad <= blk_c6 ? 1'b0 : (cp_bad || (rx_bit != prev_par));
            if (cp_slot6) febe_req <= cp_ev;
            if (is_oh && pos.sf == SF_W'(3) && blk_c)
                fe_zeros <= blk_c6 ? 2'd0 : fe_zeros + {1'b0, ~rx_bit};
            if (p_ev)   p_err_cnt   <= inc_sat(p_err_cnt);
            if (cp_ev)  cp_err_cnt  <= inc_sat(cp_err_cnt);
            if (fe_ev)  febe_cnt    <= inc_sat(febe_cnt);
            if (frm_ev) frm_err_cnt <= inc_sat(frm_err_cnt);
        end
    end

    assert_febe_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cp_slot6 && active) |-> $stable(febe_req));
    assert_p_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (p_err_cnt - $past(p_err_cnt)) <= CNT_W'(1));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_WAIT && !rx_sync) |=> $stable(frm_err_cnt));
endmodule

// File: rtl/ds3_cbit_ohg.sv
module ds3_cbit_ohg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pay_bit,
    output logic             pay_rdy,
    input  logic             rem_oof,
    input  logic             feac_bit,
    input  logic             dl_bit,
    output logic             tx_bit,
    output logic             tx_mstart,
    input  logic             rx_bit,
    input  logic             rx_sync,
    output logic [CNT_W-1:0] p_err_cnt,
    output logic [CNT_W-1:0] cp_err_cnt,
    output logic [CNT_W-1:0] febe_cnt,
    output logic [CNT_W-1:0] frm_err_cnt
);
    logic febe_req;

    ds3_cbit_tx u_tx (
        .clk(clk), .rst_n(rst_n), .pay_bit(pay_bit), .pay_rdy(pay_rdy),
        .rem_oof(rem_oof), .feac_bit(feac_bit), .dl_bit(dl_bit),
        .febe_req(febe_req), .tx_bit(tx_bit), .tx_mstart(tx_mstart)
    );

    ds3_cbit_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_sync(rx_sync),
        .febe_req(febe_req), .p_err_cnt(p_err_cnt), .cp_err_cnt(cp_err_cnt),
        .febe_cnt(febe_cnt), .frm_err_cnt(frm_err_cnt)
    );
endmodule

// File: tb/test_ds3_cbit_ohg.sv
`timescale 1ns/1ps
module test_ds3_cbit_ohg;
    localparam int FRAME  = 4760;
    localparam int SUBF   = 680;
    localparam int BLK    = 85;
    localparam int NFRM   = 7;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pay_bit = 1'b0, rem_oof = 1'b0, feac_bit = 1'b0, dl_bit = 1'b0;
    logic pay_rdy, tx_bit, tx_mstart, rx_bit, rx_sync;
    logic inj = 1'b0, sync_en = 1'b0;
    logic [CNT_W-1:0] p_err_cnt, cp_err_cnt, febe_cnt, frm_err_cnt;

    always #2 clk = ~clk;

    assign rx_bit  = tx_bit ^ inj;
    assign rx_sync = tx_mstart & sync_en;

    ds3_cbit_ohg #(.CNT_W(CNT_W)) i_ds3_cbit_ohg (
        .clk(clk), .rst_n(rst_n), .pay_bit(pay_bit), .pay_rdy(pay_rdy),
        .rem_oof(rem_oof), .feac_bit(feac_bit), .dl_bit(dl_bit),
        .tx_bit(tx_bit), .tx_mstart(tx_mstart), .rx_bit(rx_bit), .rx_sync(rx_sync),
        .p_err_cnt(p_err_cnt), .cp_err_cnt(cp_err_cnt), .febe_cnt(febe_cnt),
        .frm_err_cnt(frm_err_cnt)
    );

    typedef struct {
        int    slot;
        logic  b;
        logic  mark;
        string req;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // monitor: one entry per processed slot, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (running && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check($sformatf("%s slot %0d tx_bit", e.req, e.slot), int'(tx_bit), int'(e.b));
            check($sformatf("R1 slot %0d tx_mstart", e.slot), int'(tx_mstart), int'(e.mark));
        end
    end

    task automatic check_counts(input string tag, input int p, input int cp, input int fe, input int fr);
        check({"R10 ", tag}, int'(p_err_cnt), p);
        check({"R11 ", tag}, int'(cp_err_cnt), cp);
        check({"R12 ", tag}, int'(febe_cnt), fe);
        check({"R13 ", tag}, int'(frm_err_cnt), fr);
    endtask

    initial begin
        logic [15:0] lfsr;
        logic par_acc, par_prev, oof_lat;
        lfsr = 16'hACE1; par_acc = 1'b0; par_prev = 1'b0; oof_lat = 1'b0;
        repeat (4) @(negedge clk);
        // R2: reset state
        check("R2 reset tx_bit", int'(tx_bit), 0);
        check("R2 reset pay_rdy", int'(pay_rdy), 0);
        check_counts("R2 reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        running = 1'b1;
        for (int s = 0; s < NFRM*FRAME; s++) begin
            int fr, r, sf, blk, bt;
            exp_t e;
            fr = s / FRAME; r = s % FRAME;
            sf = r / SUBF; blk = (r % SUBF) / BLK; bt = r % BLK;
            if (r == 0) begin
                if (fr > 0) begin par_prev = par_acc; par_acc = 1'b0; end
                rem_oof  = (fr == 4);
                oof_lat  = rem_oof;
                feac_bit = fr[0];
                dl_bit   = ~fr[1];
                if (fr == 1) sync_en = 1'b1;
                // R9: unaligned frame 0 with a corrupted F bit counted nothing
                if (fr == 2) check_counts("R9 before errors", 0, 0, 0, 0);
                // R10 R11 R12: single flip in frame 2 gives one of each
                if (fr == 4) check_counts("after single flip", 1, 1, 1, 0);
            end
            check($sformatf("R1 slot %0d pay_rdy", s), int'(pay_rdy), int'(bt != 0));
            pay_bit = lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            e.slot = s; e.mark = (r == 0);
            if (bt != 0) begin
                e.b = pay_bit; e.req = "R2";
                par_acc = par_acc ^ pay_bit;
            end else begin
                unique case (blk)
                    1, 7: begin e.b = 1'b1; e.req = "R3"; end
                    3, 5: begin e.b = 1'b0; e.req = "R3"; end
                    0: begin
                        if (sf < 2)       begin e.b = ~oof_lat; e.req = "R5"; end
                        else if (sf < 4)  begin e.b = par_prev; e.req = "R6"; end
                        else              begin e.b = (sf == 5); e.req = "R4"; end
                    end
                    default: begin
                        if (sf == 0)      begin e.b = (blk == 6) ? feac_bit : 1'b1; e.req = "R7"; end
                        else if (sf == 2) begin e.b = par_prev; e.req = "R7"; end
                        else if (sf == 3) begin e.b = (fr != 3); e.req = "R8"; end
                        else              begin e.b = dl_bit; e.req = "R7"; end
                    end
                endcase
            end
            q.push_back(e);
            @(negedge clk);
            // inject on the received copy of slot s
            inj = (fr == 0 && r == 85) || (fr == 2 && r == 1000) ||
                  (fr == 4 && (r == 2000 || r == 3001)) || (fr == 5 && r == 85);
        end
        inj = 1'b0;
        repeat (4) @(negedge clk);
        // double flip in frame 4 is invisible to parity; F flip in frame 5 counted once
        check_counts("end of run R13", 1, 1, 1, 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule